// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Programmable Bit-Rate Generator

This block receives asynchronous serial characters on a single data line and hands each completed byte to the surrounding logic through a receive buffer register. A bit-rate generator feeds the receiver a 16x oversampling tick. The generator divides a selectable count source by a programmable value n+1. The count source is either the block clock itself or the block clock divided by eight.

A character has one start bit, eight data bits with the least significant bit first, and one stop bit. There is no parity bit. When the stop bit has been sampled, the byte moves from the internal shift register into the buffer. At that point a receive-complete flag and a separate interrupt request latch are both set.

The receive-complete flag clears when the buffer is read. The interrupt latch clears on an acknowledge or on a software clear. A request-to-send output throttles the remote transmitter while the buffer holds an unread character. Framing and overrun errors are reported on their own outputs.

Top module: `async_rx`

## Requirements
- R1: The generator emits one oversampling tick every (n+1) count-source cycles, so one bit lasts 16*(n+1) count-source cycles. A change of `div_n_i` or `src_sel_i` restarts the divider count.
- R2: `src_sel_i`=0 uses every clock cycle as a count-source cycle. `src_sel_i`=1 uses one clock cycle in eight.
- R3: Reception is armed only while `rx_en_i` is 1. A frame begins at a high-to-low transition on `rxd_i`. Frames that arrive while the receiver is disabled are not received.
- R4: A frame is one low start bit, eight data bits received bit 0 first, and one stop bit. When the stop bit has been sampled, the byte appears on `rx_data_o` and `rx_done_o` goes to 1.
- R5: `irq_o` is set together with the buffer load. It stays 1 until `irq_ack_i` or `irq_clr_i` is pulsed. Reading the buffer does not clear it.
- R6: Each bit is sampled on ticks 7, 8 and 9 of its 16-tick period, and its value is the 2-of-3 majority. A start bit that reads high at mid-bit is discarded, and no character results.
- R7: `rts_o` is 0 while the receiver is enabled and the buffer is empty. It is 1 while a character is unread or while the receiver is disabled. It returns to 0 when the buffer is read.
- R8: `frame_err_o` is set when a character is loaded whose stop bit sampled low. The byte is still loaded.
- R9: When a character completes while `rx_done_o` is still 1, `overrun_o` is set and `rx_data_o` keeps the earlier byte.
- R10: After reset, `rx_data_o` is 0 and all flags are 0. A `buf_rd_i` pulse clears `rx_done_o`, `frame_err_o` and `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (undivided count source) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| div_n_i | input | 8 | Rate divider value n |
| src_sel_i | input | 1 | Count source: 0 = clock, 1 = clock/8 |
| rxd_i | input | 1 | Serial data line |
| buf_rd_i | input | 1 | One-cycle buffer read strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_clr_i | input | 1 | Software clear of the interrupt latch |
| rx_data_o | output | 8 | Receive buffer register |
| rx_done_o | output | 1 | Receive-complete flag |
| irq_o | output | 1 | Interrupt request latch |
| frame_err_o | output | 1 | Framing error flag |
| overrun_o | output | 1 | Overrun error flag |
| rts_o | output | 1 | Request to send, low = ready to accept |

## Verification
The properties assume that `buf_rd_i`, `irq_ack_i` and `irq_clr_i` are single-cycle pulses. They also assume that the divider value and the source select stay constant while a frame is in flight, and that `rx_en_i` does not toggle in the middle of a frame that is expected to arrive. The stimulus changes the configuration only between frames, with the line idle high. It generates every serial bit from the same clock at exactly 16*(n+1)*prescale cycles, so sampling drift can only come from a wrong divider. Strobes are driven for exactly one cycle, away from the sampling edge.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int unsigned OVS      = 16;
  localparam int unsigned PRE_DIV  = 8;
  localparam int unsigned SMP_A    = 7;
  localparam int unsigned SMP_B    = 8;
  localparam int unsigned SMP_C    = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_rate_gen.sv
module rx_rate_gen #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned PRE_DIV = rx_pkg::PRE_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_n_i,
  input  logic             src_sel_i,
  output logic             tick_o
);
  localparam int unsigned PW = $clog2(PRE_DIV);

  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_q;
  logic             sel_q;
  logic             restart;
  logic             src_en;

  assign restart = (div_n_i != div_q) || (src_sel_i != sel_q);
  assign src_en  = src_sel_i ? (pre_cnt == PW'(PRE_DIV - 1)) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      div_q   <= '0;
      sel_q   <= 1'b0;
      tick_o  <= 1'b0;
    end else begin
      div_q <= div_n_i;
      sel_q <= src_sel_i;
      if (restart) begin
        pre_cnt <= '0;
        div_cnt <= '0;
        tick_o  <= 1'b0;
      end else begin
        pre_cnt <= (pre_cnt == PW'(PRE_DIV - 1)) ? '0 : pre_cnt + 1'b1;
        tick_o  <= 1'b0;
        if (src_en) begin
          if (div_cnt == div_n_i) begin
            div_cnt <= '0;
            tick_o  <= 1'b1;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe <= '1;
    else         pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rxd_i,
  output logic          done_o,
  output logic          stop_ok_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned TW = $clog2(OVS);
  localparam int unsigned BW = $clog2(DW);

  rx_state_e     st;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [1:0]    smp;
  logic          rxd_q;
  logic          maj;

  // 2-of-3 vote; third sample is the live line at the last sample tick
  assign maj = (smp[0] & smp[1]) | (smp[0] & rxd_i) | (smp[1] & rxd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      bcnt      <= '0;
      smp       <= '0;
      rxd_q     <= 1'b1;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
      data_o    <= '0;
    end else begin
      rxd_q  <= rxd_i;
      done_o <= 1'b0;
      if (!en_i) begin
        st <= ST_IDLE;
      end else if (st == ST_IDLE) begin
        if (rxd_q && !rxd_i) begin
          st   <= ST_START;
          tcnt <= '0;
        end
      end else if (tick_i) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == TW'(SMP_A)) smp[0] <= rxd_i;
        if (tcnt == TW'(SMP_B)) smp[1] <= rxd_i;
        if (tcnt == TW'(SMP_C)) begin
          unique case (st)
            ST_START: if (maj) st <= ST_IDLE;
            ST_DATA:  data_o <= {maj, data_o[DW-1:1]};
            ST_STOP: begin
              done_o    <= 1'b1;
              stop_ok_o <= maj;
              st        <= ST_IDLE;
            end
            default: ;
          endcase
        end
        if (tcnt == TW'(OVS - 1)) begin
          if (st == ST_START) begin
            st   <= ST_DATA;
            bcnt <= '0;
          end else if (st == ST_DATA) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == BW'(DW - 1)) st <= ST_STOP;
          end
        end
      end
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic [DIV_W-1:0] div_n_i,
  input  logic             src_sel_i,
  input  logic             rxd_i,
  input  logic             buf_rd_i,
  input  logic             irq_ack_i,
  input  logic             irq_clr_i,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_done_o,
  output logic             irq_o,
  output logic             frame_err_o,
  output logic             overrun_o,
  output logic             rts_o
);
  logic          tick;
  logic          rxd_s;
  logic          frm_done;
  logic          stop_ok;
  logic [DW-1:0] shreg;
  logic          full;

  rx_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_n_i  (div_n_i),
    .src_sel_i(src_sel_i),
    .tick_o   (tick)
  );

  rx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  rx_frame_fsm #(.DW(DW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en_i),
    .tick_i   (tick),
    .rxd_i    (rxd_s),
    .done_o   (frm_done),
    .stop_ok_o(stop_ok),
    .data_o   (shreg)
  );

  // a read in the same cycle frees the buffer for the incoming byte
  assign full = rx_done_o && !buf_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o   <= '0;
      rx_done_o   <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      if (frm_done && full) begin
        overrun_o <= 1'b1;
      end else if (frm_done) begin
        rx_data_o   <= shreg;
        rx_done_o   <= 1'b1;
        frame_err_o <= !stop_ok;
        overrun_o   <= 1'b0;
      end else if (buf_rd_i) begin
        rx_done_o   <= 1'b0;
        frame_err_o <= 1'b0;
        overrun_o   <= 1'b0;
      end

      if (frm_done && !full)        irq_o <= 1'b1;
      else if (irq_ack_i || irq_clr_i) irq_o <= 1'b0;
    end
  end

  assign rts_o = !(rx_en_i && !rx_done_o);
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic [DIV_W-1:0] div_n_i,
  input logic             buf_rd_i,
  input logic             irq_ack_i,
  input logic             irq_clr_i,
  input logic [DW-1:0]    rx_data_o,
  input logic             rx_done_o,
  input logic             irq_o,
  input logic             overrun_o,
  input logic             tick,
  input logic             frm_done
);
  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_n_i != '0 && tick) |=> !tick);

  a_r3_done_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_done |-> rx_en_i);

  a_r4_done_from_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> $past(frm_done));

  a_r5_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i && !irq_clr_i) |=> irq_o);

  a_r5_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_ack_i || irq_clr_i) && !frm_done) |=> !irq_o);

  a_r9_buf_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !buf_rd_i) |=> $stable(rx_data_o));

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_rd_i && !frm_done) |=> (!rx_done_o && !overrun_o));
endmodule

bind async_rx async_rx_chk #(.DW(DW), .DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rx_en_i  (rx_en_i),
  .div_n_i  (div_n_i),
  .buf_rd_i (buf_rd_i),
  .irq_ack_i(irq_ack_i),
  .irq_clr_i(irq_clr_i),
  .rx_data_o(rx_data_o),
  .rx_done_o(rx_done_o),
  .irq_o    (irq_o),
  .overrun_o(overrun_o),
  .tick     (tick),
  .frm_done (frm_done)
);

// File: tb/async_rx_bench.sv
module async_rx_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_en_i = 1'b0;
  logic [7:0] div_n_i = 8'd0;
  logic       src_sel_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       buf_rd_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_done_o, irq_o, frame_err_o, overrun_o, rts_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  async_rx u_async_rx (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (int'(div_n_i) + 1) * (src_sel_i ? 8 : 1);
  endfunction

  task automatic hold(input logic v, input int cyc);
    rxd_i = v;
    repeat (cyc) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    int bc;
    bc = bit_clks();
    hold(1'b0, bc);
    for (int i = 0; i < 8; i++) hold(b[i], bc);
    hold(stop, bc);
    rxd_i = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse_rd();
    buf_rd_i = 1'b1; @(negedge clk_i); buf_rd_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic pulse_ack();
    irq_ack_i = 1'b1; @(negedge clk_i); irq_ack_i = 1'b0; @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    repeat (3) @(negedge clk_i);
    // R10 reset state; R7 rts high while disabled
    chk("R10 data", rx_data_o, 0);
    chk("R10 done", rx_done_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 ferr", frame_err_o, 0);
    chk("R10 ovr", overrun_o, 0);
    chk("R7 rts disabled", rts_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 after release done", rx_done_o, 0);

    // R3 disabled: frame ignored
    div_n_i = 8'd1;
    repeat (4) @(negedge clk_i);
    send(8'h3C, 1'b1);
    chk("R3 disabled no done", rx_done_o, 0);
    chk("R3 disabled data", rx_data_o, 0);

    rx_en_i = 1'b1;
    @(negedge clk_i);
    chk("R7 rts enabled empty", rts_o, 0);

    // R1 R2 R4 R5 R7 sweep over source and divider
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) begin
        src_sel_i = s[0];
        div_n_i   = 8'(n);
        repeat (20) @(negedge clk_i);
        for (int k = 0; k < 2; k++) begin
          pat = 8'hA5 ^ 8'(n * 37 + s * 91 + k * 200);
          send(pat, 1'b1);
          chk("R1 R2 R4 data", rx_data_o, pat);
          chk("R4 done", rx_done_o, 1);
          chk("R5 irq set", irq_o, 1);
          chk("R8 ferr clear", frame_err_o, 0);
          chk("R7 rts full", rts_o, 1);
          pulse_rd();
          chk("R5 irq survives read", irq_o, 1);
          chk("R10 read clears done", rx_done_o, 0);
          chk("R7 rts after read", rts_o, 0);
          pulse_ack();
          chk("R5 ack clears irq", irq_o, 0);
        end
      end
    end

    src_sel_i = 1'b0;
    div_n_i   = 8'd1;
    repeat (20) @(negedge clk_i);

    // R5 software clear
    send(8'h81, 1'b1);
    irq_clr_i = 1'b1; @(negedge clk_i); irq_clr_i = 1'b0; @(negedge clk_i);
    chk("R5 sw clear irq", irq_o, 0);
    chk("R5 sw clear keeps done", rx_done_o, 1);
    pulse_rd();

    // R9 overrun
    send(8'h5A, 1'b1);
    send(8'hC3, 1'b1);
    chk("R9 ovr set", overrun_o, 1);
    chk("R9 old data kept", rx_data_o, 8'h5A);
    chk("R9 done stays", rx_done_o, 1);
    pulse_rd();
    chk("R10 read clears ovr", overrun_o, 0);
    pulse_ack();

    // R8 framing error
    send(8'h96, 1'b0);
    hold(1'b1, bit_clks());
    chk("R8 ferr set", frame_err_o, 1);
    chk("R8 byte loaded", rx_data_o, 8'h96);
    pulse_rd();
    chk("R10 read clears ferr", frame_err_o, 0);
    pulse_ack();

    // R6 start glitch rejected, then a clean frame still received
    hold(1'b0, 4 * 2);
    hold(1'b1, 3 * bit_clks());
    chk("R6 glitch no done", rx_done_o, 0);
    chk("R6 glitch no irq", irq_o, 0);
    send(8'h1F, 1'b1);
    chk("R6 frame after glitch", rx_data_o, 8'h1F);

    // R6 majority: one corrupted sample inside a bit is outvoted
    pulse_rd();
    pulse_ack();
    begin
      int bc;
      bc = bit_clks();
      hold(1'b0, bc);
      // bit0 = 1 with a one-tick low blip near mid-bit
      hold(1'b1, bc / 2 - 2);
      hold(1'b0, 2);
      hold(1'b1, bc - bc / 2);
      for (int i = 1; i < 8; i++) hold(1'b0, bc);
      hold(1'b1, bc);
      repeat (4) @(negedge clk_i);
    end
    chk("R6 vote outvotes blip", rx_data_o, 8'h01);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule